// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked sequencer that turns single-word host requests into the strobe sequences that an external asynchronous static RAM of 32K x 8 needs. The host offers a request with valid, a write flag, a 15-bit address and a write byte. It sees ready while the controller is idle and a one-cycle done pulse when the access finishes. A read returns its byte on the read-data port in that same cycle.

On the memory side the controller drives active-low chip enable, output enable and write enable, plus the address. The data bus is split into an outgoing byte, an incoming byte and an enable for the external tri-state driver. Every timing wait is a clock-cycle count. Each count is the ceiling of a nanosecond limit divided by the clock period, never less than 1, and is fixed at elaboration for the chosen speed grade: 0 for the 35 ns part, 1 for the 70 ns part. All strobes and the driver enable come straight from flip-flops, so none of them can glitch.

Top module: `asram_ctl`

## Requirements
- R1: While reset is held and right after it, chip enable, output enable and write enable are high (inactive), the bus driver enable is low, done is low and ready is high.
- R2: During a read, chip enable and output enable are low, write enable is high and the bus driver is off, from the cycle after acceptance until the data is captured.
- R3: Read data is captured from the memory only after chip enable, output enable and address have been stable for the read count of cycles. That count is the largest of the ceilings of the read-cycle, address-access, enable-access and output-enable-access limits. The captured byte is presented on the read-data port in the done cycle.
- R4: During a write, output enable stays high and write enable is low only while chip enable is low. The write-enable low pulse lasts at least the pulse count of cycles, and the byte driven last before write enable rises is the one stored. A second write to the same address replaces the first.
- R5: The bus driver enable is high only while write enable is low and output enable is high. It is off in the first cycle of the write pulse and turns off no later than the edge at which write enable rises. The outgoing byte is driven for at least the ceiling of the data-setup limit before the end of the write.
- R6: The memory address changes only when chip enable or write enable is high. It is loaded only at the edge that accepts a request and is then held until the next acceptance.
- R7: ready is high only while the sequencer is idle. A request is taken only at an edge where valid and ready are both high. done is high for exactly one cycle per transaction, and ready is low during that cycle.
- R8: At the 35 ns grade with a 10 ns clock, done is seen 4 cycles after the accepting edge for a read. For a write it is seen setup + pulse + recovery - 1 = 4 cycles after.
- R9: The read-data port keeps the byte of the last completed read through later writes and idle cycles, whatever the memory drives onto its data input at those times.
- R10: Each count is computed as ceil(ns / period) with a minimum of 1. The write pulse count is the largest of the pulse-width limit, one cycle plus the data-setup count, and the enable-to-end and address-to-end limits less the setup count. The recovery count stretches the write so that it covers the full write-cycle limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_done | output | 1 | One-cycle pulse at the end of a transaction |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dout | output | 8 | Byte toward the memory bus |
| mem_din | input | 8 | Byte from the memory bus |
| mem_dout_en | output | 1 | Enable for the external bus driver |

## Verification
The bench's memory model returns the inverted byte until the read count has passed since the enables and address settled. A controller that samples one cycle early therefore reads back wrong data on every address of the sweep. The model also measures each write-enable pulse and each driver window. A pulse that is too short, a driver that turns on with the falling strobe or lingers after it, or output enable low during a write each leave a violation count that the bench reports. The sweep covers walking-one addresses, both ends of the address range, overwrites and back-to-back requests. An address that moves while both strobes are low is caught at once, and a read-data register that follows the data input outside a read shows up when the bench checks that value after a write.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RD_ACCESS  = 3'd1,
      ST_RD_DONE    = 3'd2,
      ST_WR_SETUP   = 3'd3,
      ST_WR_PULSE   = 3'd4,
      ST_WR_RECOVER = 3'd5
   } seq_state_t;

   typedef enum int {
      TP_RD_CYCLE,
      TP_ADDR_ACC,
      TP_CE_ACC,
      TP_OE_ACC,
      TP_WR_CYCLE,
      TP_WE_PULSE,
      TP_ADDR_END,
      TP_CE_END,
      TP_DATA_SETUP,
      TP_ADDR_SETUP,
      TP_WR_RECOVERY
   } tparam_e;

   // nanosecond limits per speed grade (0 = 35 ns part, 1 = 70 ns part)
   function automatic int grade_ns(input int grade, input tparam_e p);
      int fast_v;
      int slow_v;
      case (p)
         TP_RD_CYCLE:    begin fast_v = 35; slow_v = 70; end
         TP_ADDR_ACC:    begin fast_v = 35; slow_v = 70; end
         TP_CE_ACC:      begin fast_v = 35; slow_v = 70; end
         TP_OE_ACC:      begin fast_v = 25; slow_v = 35; end
         TP_WR_CYCLE:    begin fast_v = 35; slow_v = 70; end
         TP_WE_PULSE:    begin fast_v = 25; slow_v = 50; end
         TP_ADDR_END:    begin fast_v = 30; slow_v = 60; end
         TP_CE_END:      begin fast_v = 30; slow_v = 60; end
         TP_DATA_SETUP:  begin fast_v = 20; slow_v = 30; end
         default:        begin fast_v = 0;  slow_v = 0;  end
      endcase
      return (grade == 0) ? fast_v : slow_v;
   endfunction

   // ceiling of ns over the clock period (given in ps), never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
   import asram_pkg::*;
#(
   parameter int CNT_W  = 3,
   parameter int RD_CYC = 4,
   parameter int WS_CYC = 1,
   parameter int WP_CYC = 3,
   parameter int WR_CYC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             cnt_expired,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   output logic             accept,
   output logic             capture,
   output logic             req_ready,
   output logic             rsp_done,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             drv_en
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WS_LD = CNT_W'(WS_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
   localparam int               WL_W  = $clog2(WP_CYC + 2);

   seq_state_t state_q, state_d;
   logic       ce_n_q, oe_n_q, we_n_q, drv_q;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               cnt_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_SETUP;
                  cnt_val = WS_LD;
               end else begin
                  state_d = ST_RD_ACCESS;
                  cnt_val = RD_LD;
               end
            end
         end
         ST_RD_ACCESS: begin
            if (cnt_expired) state_d = ST_RD_DONE;
         end
         ST_RD_DONE: begin
            state_d = ST_IDLE;
         end
         ST_WR_SETUP: begin
            if (cnt_expired) begin
               state_d  = ST_WR_PULSE;
               cnt_load = 1'b1;
               cnt_val  = WP_LD;
            end
         end
         ST_WR_PULSE: begin
            if (cnt_expired) begin
               state_d  = ST_WR_RECOVER;
               cnt_load = 1'b1;
               cnt_val  = WR_LD;
            end
         end
         ST_WR_RECOVER: begin
            if (cnt_expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ce_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         drv_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ce_n_q  <= !(state_d == ST_RD_ACCESS || state_d == ST_WR_SETUP ||
                      state_d == ST_WR_PULSE);
         oe_n_q  <= !(state_d == ST_RD_ACCESS);
         we_n_q  <= !(state_d == ST_WR_PULSE);
         // driver comes on one cycle after the write strobe falls
         drv_q   <= (state_d == ST_WR_PULSE) && (state_q == ST_WR_PULSE);
      end
   end

   assign accept    = (state_q == ST_IDLE) && req_valid;
   assign capture   = (state_q == ST_RD_ACCESS) && cnt_expired;
   assign req_ready = (state_q == ST_IDLE);
   assign rsp_done  = (state_q == ST_RD_DONE) ||
                      ((state_q == ST_WR_RECOVER) && cnt_expired);
   assign ce_n      = ce_n_q;
   assign oe_n      = oe_n_q;
   assign we_n      = we_n_q;
   assign drv_en    = drv_q;

   // length of the current write-enable low pulse, for the checker below
   logic [WL_W-1:0] wl_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n || we_n_q) begin
         wl_cnt_q <= '0;
      end else if (wl_cnt_q != {WL_W{1'b1}}) begin
         wl_cnt_q <= wl_cnt_q + 1'b1;
      end
   end

   // R4
   we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_q |-> !ce_n_q);
   // R4
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n_q && !oe_n_q));
   // R4
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n_q) |-> (int'(wl_cnt_q) >= WP_CYC));
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ce_n_q && oe_n_q && we_n_q && !drv_q && !rsp_done));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_din,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              drv_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture) begin
         rdata_q <= mem_din;
      end
   end

   assign mem_addr  = addr_q;
   assign mem_dout  = wdata_q;
   assign rsp_rdata = rdata_q;

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !we_n) |=> $stable(addr_q));
   // R5
   drv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (!we_n && oe_n));
   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ce_n && !oe_n) |=> $stable(rdata_q));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int CLK_PS      = 10000,
   parameter int SPEED_GRADE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_dout_en
);

   // R10: cycle counts derived from the grade's ns limits
   localparam int RD_CYC = max_of(
      max_of(ns_to_cyc(grade_ns(SPEED_GRADE, TP_RD_CYCLE), CLK_PS),
             ns_to_cyc(grade_ns(SPEED_GRADE, TP_ADDR_ACC), CLK_PS)),
      max_of(ns_to_cyc(grade_ns(SPEED_GRADE, TP_CE_ACC), CLK_PS),
             ns_to_cyc(grade_ns(SPEED_GRADE, TP_OE_ACC), CLK_PS)));
   localparam int WS_CYC = ns_to_cyc(grade_ns(SPEED_GRADE, TP_ADDR_SETUP), CLK_PS);
   localparam int WP_CYC = max_of(
      max_of(ns_to_cyc(grade_ns(SPEED_GRADE, TP_WE_PULSE), CLK_PS),
             1 + ns_to_cyc(grade_ns(SPEED_GRADE, TP_DATA_SETUP), CLK_PS)),
      max_of(ns_to_cyc(grade_ns(SPEED_GRADE, TP_CE_END), CLK_PS) - WS_CYC,
             ns_to_cyc(grade_ns(SPEED_GRADE, TP_ADDR_END), CLK_PS) - WS_CYC));
   localparam int WR_CYC = max_of(
      ns_to_cyc(grade_ns(SPEED_GRADE, TP_WR_RECOVERY), CLK_PS),
      ns_to_cyc(grade_ns(SPEED_GRADE, TP_WR_CYCLE), CLK_PS) - WS_CYC - WP_CYC);
   localparam int MAX_CYC = max_of(max_of(RD_CYC, WS_CYC), max_of(WP_CYC, WR_CYC));
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("asram_ctl: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("asram_ctl: DATA_W must be positive");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("asram_ctl: CLK_PS must be positive");
      end
      if (SPEED_GRADE != 0 && SPEED_GRADE != 1) begin : g_bad_grade
         $error("asram_ctl: SPEED_GRADE must be 0 or 1");
      end
      if (WP_CYC < 2) begin : g_bad_pulse
         $error("asram_ctl: write pulse needs at least two cycles");
      end
   endgenerate

   logic             cnt_load;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_expired;
   logic             accept;
   logic             capture;
   logic             ce_n, oe_n, we_n, drv_en;

   asram_wait_cnt #(
      .CNT_W (CNT_W)
   ) wait_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .expired  (cnt_expired)
   );

   asram_seq_fsm #(
      .CNT_W  (CNT_W),
      .RD_CYC (RD_CYC),
      .WS_CYC (WS_CYC),
      .WP_CYC (WP_CYC),
      .WR_CYC (WR_CYC)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .cnt_expired (cnt_expired),
      .cnt_load    (cnt_load),
      .cnt_val     (cnt_val),
      .accept      (accept),
      .capture     (capture),
      .req_ready   (req_ready),
      .rsp_done    (rsp_done),
      .ce_n        (ce_n),
      .oe_n        (oe_n),
      .we_n        (we_n),
      .drv_en      (drv_en)
   );

   asram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) dp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_din   (mem_din),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .drv_en    (drv_en),
      .mem_addr  (mem_addr),
      .mem_dout  (mem_dout),
      .rsp_rdata (rsp_rdata)
   );

   assign mem_ce_n    = ce_n;
   assign mem_oe_n    = oe_n;
   assign mem_we_n    = we_n;
   assign mem_dout_en = drv_en;

   // R2
   read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dout_en));

endmodule

// File: tb/asram_ctl_tb_top.sv
module asram_ctl_tb_top;

   localparam int CLK_NS = 10;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + CLK_NS - 1) / CLK_NS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // 35 ns grade limits, converted here independently of the design
   localparam int E_RD  = mx(mx(cyc(35), cyc(35)), cyc(25));
   localparam int E_WS  = cyc(0);
   localparam int E_WP  = mx(mx(cyc(25), 1 + cyc(20)), cyc(30) - E_WS);
   localparam int E_WR  = mx(cyc(0), cyc(35) - E_WS - E_WP);
   localparam int E_DS  = cyc(20);
   localparam int E_RLAT = E_RD;
   localparam int E_WLAT = E_WS + E_WP + E_WR - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  rsp_rdata;
   logic        rsp_done;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dout;
   logic [7:0]  mem_din = 8'h5A;

   always #5 clk = ~clk;

   asram_ctl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .rsp_rdata   (rsp_rdata),
      .rsp_done    (rsp_done),
      .mem_ce_n    (mem_ce_n),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .mem_addr    (mem_addr),
      .mem_dout    (mem_dout),
      .mem_din     (mem_din),
      .mem_dout_en (mem_dout_en)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // cycle-level memory model, observed at the falling edge
   logic [7:0] mem_store [int];
   int  rd_age = 0;
   int  wl_len = 0;
   int  ds_len = 0;
   logic [7:0] wbuf = '0;
   logic [14:0] prev_addr = '0;
   bit  prev_low = 0;
   int  v_addr = 0, v_pulse = 0, v_setup = 0, v_oe = 0;

   function automatic logic [7:0] stored(input logic [14:0] a);
      return mem_store.exists(int'(a)) ? mem_store[int'(a)] : 8'hFF;
   endfunction

   always @(negedge clk) begin
      bit rd_now, wr_now;
      rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
      wr_now = !mem_ce_n && !mem_we_n;
      if ((wr_now || rd_now) && prev_low && mem_addr != prev_addr) v_addr++;
      if (rd_now) rd_age++; else rd_age = 0;
      if (wr_now) begin
         wl_len++;
         if (!mem_oe_n) v_oe++;
         if (mem_dout_en) begin ds_len++; wbuf = mem_dout; end
      end else if (wl_len > 0) begin
         if (wl_len < E_WP) v_pulse++;
         if (ds_len < E_DS) v_setup++;
         mem_store[int'(mem_addr)] = wbuf;
         wl_len = 0;
         ds_len = 0;
      end
      if (mem_dout_en && mem_we_n) v_setup++;
      mem_din <= rd_now ? ((rd_age >= E_RD) ? stored(mem_addr) : ~stored(mem_addr))
                        : 8'h5A;
      prev_low  = wr_now || rd_now;
      prev_addr = mem_addr;
   end

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL R7 watchdog: actual %0d expected below 100000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   function automatic logic [7:0] pat(input logic [14:0] a, input int salt);
      return a[7:0] ^ {a[14:8], 1'b1} ^ 8'(salt * 37 + 8'h3C);
   endfunction

   function automatic logic [14:0] sweep_addr(input int i);
      if (i < 15) return 15'(1 << i);
      if (i == 15) return 15'h0000;
      if (i == 16) return 15'h7FFF;
      return 15'((i * 1031 + 17) & 32'h7FFF);
   endfunction

   // issue one request; returns observed latency and read byte
   task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        output int lat, output logic [7:0] rd);
      int guard;
      guard = 0;
      while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      // R7: busy right after acceptance
      chk(!req_ready, "R7", "ready after accept", int'(req_ready), 0);
      if (!wr) begin
         // R2: read strobes in the first access cycle
         chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dout_en, "R2",
             "read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 4'b0010);
      end
      lat = 0;
      while (!rsp_done && lat < 50) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
      chk(!req_ready, "R7", "ready in done cycle", int'(req_ready), 0);
      @(negedge clk);
      chk(!rsp_done && req_ready, "R7", "done single pulse",
          {rsp_done, req_ready}, 2'b01);
   endtask

   initial begin
      int lat;
      logic [7:0] rd;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en, "R1", "strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 4'b1110);
      chk(req_ready && !rsp_done, "R1", "ready/done in reset", {req_ready, rsp_done}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && req_ready, "R1",
          "state after release", {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, req_ready},
          5'b11101);

      // R4 R8 R10: write sweep
      for (int i = 0; i < 50; i++) begin
         do_op(1'b1, sweep_addr(i), pat(sweep_addr(i), 0), lat, rd);
         chk(lat == E_WLAT, "R8", "write latency", lat, E_WLAT);
      end

      // R4: overwrite a few addresses, last write wins
      for (int i = 0; i < 4; i++) begin
         do_op(1'b1, sweep_addr(i * 5), pat(sweep_addr(i * 5), 1), lat, rd);
      end

      // R3 R8: read sweep
      for (int i = 0; i < 50; i++) begin
         logic [7:0] exp;
         exp = ((i % 5) == 0 && i < 20) ? pat(sweep_addr(i), 1) : pat(sweep_addr(i), 0);
         do_op(1'b0, sweep_addr(i), 8'h00, lat, rd);
         chk(rd == exp, "R3", "read data", int'(rd), int'(exp));
         chk(lat == E_RLAT, "R8", "read latency", lat, E_RLAT);
      end

      // R9: read-data port holds across a write and idle cycles
      do_op(1'b0, 15'h7FFF, 8'h00, lat, held);
      do_op(1'b1, 15'h1234, ~held, lat, rd);
      repeat (3) @(negedge clk);
      chk(rsp_rdata == held, "R9", "read byte held", int'(rsp_rdata), int'(held));
      do_op(1'b0, 15'h1234, 8'h00, lat, rd);
      chk(rd == ~held, "R4", "late write stored", int'(rd), int'(~held));

      // model-side timing checks
      chk(v_addr == 0, "R6", "address moved under strobes", v_addr, 0);
      chk(v_pulse == 0, "R4", "short write pulses", v_pulse, 0);
      chk(v_oe == 0, "R4", "output enable low in write", v_oe, 0);
      chk(v_setup == 0, "R5", "driver window violations", v_setup, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule